// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits behind the decode stage of an in-order core that has two execution pipes of unequal capability: a full pipe that can run any operation and a restricted pipe that runs only simple operations. Each cycle it looks at the two oldest decoded instructions, in program order, and decides whether both may leave together. The older instruction (slot 0) always goes to the full pipe. The younger one (slot 1) goes to the restricted pipe only when the pair passes every rule. Otherwise only slot 0 issues, and the issue logic presents the old slot 1 as the next cycle's slot 0.

The rules cover several things. Some classes may never pair, and each instruction also carries a "solo" attribute. A branch may pair only from the younger slot. The restricted pipe accepts only certain classes. A read-after-write between the two instructions blocks the pair, and the check knows which parts of a register overlap. Two writes to the same register block the pair, whichever parts they touch.

The decision is computed combinationally and registered on the clock edge, together with a reason code. When either slot is empty, no decision is given. In that case the surrounding issue logic handles a lone instruction on its own.

Top module: `dual_issue_pair_chk`

## Requirements
- R1: The outputs change one clock edge after the inputs they reflect. During reset all outputs are 0. `dec_valid` is 1 only when both `s0_valid` and `s1_valid` were 1 at the previous edge, and when it is 0, `dec_full_go`, `dec_lite_go`, `dec_single` and `dec_why` are all 0.
- R2: The class field is 4 bits, with 0 move, 1 address compute, 2 simple ALU, 3 push/pop, 4 test/compare, 5 branch/call, 6 shift/rotate, 7 floating point, 8 multiply, 9 divide, 10 push-all, 11 string move, and 12 to 15 reserved. Class 8 to 15 in either slot, or a set solo bit in either slot, blocks the pair with reason 3.
- R3: Class 5 in slot 0 blocks the pair with reason 5. Class 5 in slot 1 is allowed.
- R4: Slot 1 with class 6 or 7 blocks the pair with reason 4. Slot 0 with class 6 or 7 is allowed.
- R5: Each source of slot 1 is checked against the destination of slot 0. If that source is enabled, names the same register as an enabled slot-0 destination, and the two parts overlap, the pair is blocked with reason 1. Part codes are 0 full, 1 low half, 2 low byte, 3 high byte. Source j occupies bits [3j+2:3j] of the register field and [2j+1:2j] of the part field.
- R6: The low byte and the high byte do not overlap each other. Every other pair of parts overlaps, including a part with itself. Writing the low byte and then reading the high byte of the same register therefore still pairs.
- R7: When both destinations are enabled and name the same register, the pair is blocked with reason 2, whatever parts the two writes touch.
- R8: When several rules fail at once, the reason reported is the first failing rule in this order: class/solo (3), branch in slot 0 (5), restricted pipe capability (4), read-after-write (1), write-after-write (2).
- R9: Whenever `dec_valid` is 1, `dec_full_go` is 1 and exactly one of `dec_lite_go` and `dec_single` is 1.
- R10: With both slots valid and no rule failing, `dec_lite_go` is 1 and `dec_why` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s0_valid | input | 1 | Slot 0 (older) holds an instruction |
| s0_cls | input | 4 | Slot 0 class |
| s0_solo | input | 1 | Slot 0 must issue alone |
| s0_dst_en | input | 1 | Slot 0 writes a register |
| s0_dst_reg | input | 3 | Slot 0 destination register |
| s0_dst_part | input | 2 | Slot 0 destination part |
| s1_valid | input | 1 | Slot 1 (younger) holds an instruction |
| s1_cls | input | 4 | Slot 1 class |
| s1_solo | input | 1 | Slot 1 must issue alone |
| s1_dst_en | input | 1 | Slot 1 writes a register |
| s1_dst_reg | input | 3 | Slot 1 destination register |
| s1_src_en | input | 2 | Slot 1 source enables |
| s1_src_reg | input | 6 | Slot 1 source registers, packed |
| s1_src_part | input | 4 | Slot 1 source parts, packed |
| dec_valid | output | 1 | A decision is present |
| dec_full_go | output | 1 | Slot 0 issues to the full pipe |
| dec_lite_go | output | 1 | Slot 1 issues to the restricted pipe too |
| dec_single | output | 1 | Only slot 0 issues |
| dec_why | output | 3 | Reason code for the decision, 0 when paired |

## Verification
Any error in the rule evaluation shows up at the output one clock edge after the offending pair is presented. It appears as a pair that should have been blocked, a blocked pair that was legal, or a wrong reason code. The most likely faults are a flipped part-overlap case, a mis-ordered priority, or a wrong class range. Each of these changes only a narrow set of input combinations. For that reason, the class pairs, the register/part combinations and the solo bits are swept exhaustively, and a long pseudo-random run then mixes the rules to expose priority faults.

// File: rtl/pair_pkg.sv
package pair_pkg;
  localparam int CLS_W  = 4;
  localparam int PART_W = 2;
  localparam int WHY_W  = 3;

  localparam logic [CLS_W-1:0] CLS_MOV     = 4'd0;
  localparam logic [CLS_W-1:0] CLS_LEA     = 4'd1;
  localparam logic [CLS_W-1:0] CLS_ALU     = 4'd2;
  localparam logic [CLS_W-1:0] CLS_STACK   = 4'd3;
  localparam logic [CLS_W-1:0] CLS_CMP     = 4'd4;
  localparam logic [CLS_W-1:0] CLS_BRANCH  = 4'd5;
  localparam logic [CLS_W-1:0] CLS_SHIFT   = 4'd6;
  localparam logic [CLS_W-1:0] CLS_FLOAT   = 4'd7;
  localparam logic [CLS_W-1:0] CLS_MUL     = 4'd8;

  localparam logic [PART_W-1:0] PART_FULL = 2'd0;
  localparam logic [PART_W-1:0] PART_HALF = 2'd1;
  localparam logic [PART_W-1:0] PART_LO   = 2'd2;
  localparam logic [PART_W-1:0] PART_HI   = 2'd3;

  localparam logic [WHY_W-1:0] WHY_NONE   = 3'd0;
  localparam logic [WHY_W-1:0] WHY_RAW    = 3'd1;
  localparam logic [WHY_W-1:0] WHY_WAW    = 3'd2;
  localparam logic [WHY_W-1:0] WHY_CLASS  = 3'd3;
  localparam logic [WHY_W-1:0] WHY_LITE   = 3'd4;
  localparam logic [WHY_W-1:0] WHY_BRANCH = 3'd5;

  // Low and high byte are disjoint; every other pairing shares bits.
  function automatic logic parts_overlap(input logic [PART_W-1:0] a,
                                         input logic [PART_W-1:0] b);
    logic disjoint;
    disjoint = (a == PART_LO && b == PART_HI) || (a == PART_HI && b == PART_LO);
    return !disjoint;
  endfunction

  // Multiply and everything above it never pairs.
  function automatic logic class_never(input logic [CLS_W-1:0] c);
    return c >= CLS_MUL;
  endfunction

  // Restricted pipe runs only the simple classes up to branch.
  function automatic logic class_lite_ok(input logic [CLS_W-1:0] c);
    return c <= CLS_BRANCH;
  endfunction
endpackage

// File: rtl/pair_hazard.sv
module pair_hazard
  import pair_pkg::*;
#(
  parameter int REG_W   = 3,
  parameter int NUM_SRC = 2
) (
  input  logic                      p_dst_en,
  input  logic [REG_W-1:0]          p_dst_reg,
  input  logic [PART_W-1:0]         p_dst_part,
  input  logic                      q_dst_en,
  input  logic [REG_W-1:0]          q_dst_reg,
  input  logic [NUM_SRC-1:0]        q_src_en,
  input  logic [NUM_SRC*REG_W-1:0]  q_src_reg,
  input  logic [NUM_SRC*PART_W-1:0] q_src_part,
  output logic                      raw_hit,
  output logic                      waw_hit
);
  logic [NUM_SRC-1:0] src_hit;

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      assign src_hit[g] = p_dst_en && q_src_en[g]
                       && (q_src_reg[g*REG_W +: REG_W] == p_dst_reg)
                       && parts_overlap(p_dst_part, q_src_part[g*PART_W +: PART_W]);
    end
  endgenerate

  assign raw_hit = |src_hit;
  // Any two writes to one register conflict, even to disjoint bytes.
  assign waw_hit = p_dst_en && q_dst_en && (p_dst_reg == q_dst_reg);
endmodule

// File: rtl/pair_capability.sv
module pair_capability
  import pair_pkg::*;
(
  input  logic [CLS_W-1:0] a_cls,
  input  logic             a_solo,
  input  logic [CLS_W-1:0] b_cls,
  input  logic             b_solo,
  output logic             never_hit,
  output logic             branch_first,
  output logic             lite_reject
);
  assign never_hit    = class_never(a_cls) || class_never(b_cls) || a_solo || b_solo;
  assign branch_first = (a_cls == CLS_BRANCH);
  assign lite_reject  = !class_lite_ok(b_cls);
endmodule

// File: rtl/pair_decide.sv
module pair_decide
  import pair_pkg::*;
(
  input  logic             both_valid,
  input  logic             never_hit,
  input  logic             branch_first,
  input  logic             lite_reject,
  input  logic             raw_hit,
  input  logic             waw_hit,
  output logic             go_pair,
  output logic             go_single,
  output logic [WHY_W-1:0] why
);
  always_comb begin
    why = WHY_NONE;
    if (!both_valid)       why = WHY_NONE;
    else if (never_hit)    why = WHY_CLASS;
    else if (branch_first) why = WHY_BRANCH;
    else if (lite_reject)  why = WHY_LITE;
    else if (raw_hit)      why = WHY_RAW;
    else if (waw_hit)      why = WHY_WAW;
    go_pair   = both_valid && (why == WHY_NONE);
    go_single = both_valid && (why != WHY_NONE);
  end
endmodule

// File: rtl/dual_issue_pair_chk.sv
module dual_issue_pair_chk
  import pair_pkg::*;
#(
  parameter int REG_W   = 3,
  parameter int NUM_SRC = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      s0_valid,
  input  logic [CLS_W-1:0]          s0_cls,
  input  logic                      s0_solo,
  input  logic                      s0_dst_en,
  input  logic [REG_W-1:0]          s0_dst_reg,
  input  logic [PART_W-1:0]         s0_dst_part,
  input  logic                      s1_valid,
  input  logic [CLS_W-1:0]          s1_cls,
  input  logic                      s1_solo,
  input  logic                      s1_dst_en,
  input  logic [REG_W-1:0]          s1_dst_reg,
  input  logic [NUM_SRC-1:0]        s1_src_en,
  input  logic [NUM_SRC*REG_W-1:0]  s1_src_reg,
  input  logic [NUM_SRC*PART_W-1:0] s1_src_part,
  output logic                      dec_valid,
  output logic                      dec_full_go,
  output logic                      dec_lite_go,
  output logic                      dec_single,
  output logic [WHY_W-1:0]          dec_why
);
  logic             both_valid;
  logic             raw_hit, waw_hit;
  logic             never_hit, branch_first, lite_reject;
  logic             go_pair, go_single;
  logic [WHY_W-1:0] why_nxt;

  assign both_valid = s0_valid && s1_valid;

  pair_hazard #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_hazard (
    .p_dst_en   (s0_dst_en),
    .p_dst_reg  (s0_dst_reg),
    .p_dst_part (s0_dst_part),
    .q_dst_en   (s1_dst_en),
    .q_dst_reg  (s1_dst_reg),
    .q_src_en   (s1_src_en),
    .q_src_reg  (s1_src_reg),
    .q_src_part (s1_src_part),
    .raw_hit    (raw_hit),
    .waw_hit    (waw_hit)
  );

  pair_capability u_cap (
    .a_cls        (s0_cls),
    .a_solo       (s0_solo),
    .b_cls        (s1_cls),
    .b_solo       (s1_solo),
    .never_hit    (never_hit),
    .branch_first (branch_first),
    .lite_reject  (lite_reject)
  );

  pair_decide u_decide (
    .both_valid   (both_valid),
    .never_hit    (never_hit),
    .branch_first (branch_first),
    .lite_reject  (lite_reject),
    .raw_hit      (raw_hit),
    .waw_hit      (waw_hit),
    .go_pair      (go_pair),
    .go_single    (go_single),
    .why          (why_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid   <= 1'b0;
      dec_full_go <= 1'b0;
      dec_lite_go <= 1'b0;
      dec_single  <= 1'b0;
      dec_why     <= WHY_NONE;
    end else begin
      dec_valid   <= both_valid;
      dec_full_go <= both_valid;
      dec_lite_go <= go_pair;
      dec_single  <= go_single;
      dec_why     <= why_nxt;
    end
  end

  assert_withheld_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !both_valid |=> (!dec_valid && !dec_lite_go && !dec_single));

  assert_never_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (both_valid && never_hit) |=> (!dec_lite_go && dec_why == WHY_CLASS));

  assert_branch_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (both_valid && branch_first) |=> !dec_lite_go);

  assert_lite_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (both_valid && lite_reject) |=> !dec_lite_go);

  assert_raw_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (both_valid && raw_hit) |=> !dec_lite_go);

  assert_waw_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (both_valid && waw_hit) |=> !dec_lite_go);

  assert_pair_reason_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_lite_go |-> (dec_why == WHY_NONE));

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_full_go && $countones({dec_lite_go, dec_single}) == 1));
endmodule

// File: tb/dual_issue_pair_chk_tb.sv
`timescale 1ns/100ps
module dual_issue_pair_chk_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s0_valid, s0_solo, s0_dst_en;
  logic [3:0] s0_cls;
  logic [2:0] s0_dst_reg;
  logic [1:0] s0_dst_part;
  logic       s1_valid, s1_solo, s1_dst_en;
  logic [3:0] s1_cls;
  logic [2:0] s1_dst_reg;
  logic [1:0] s1_src_en;
  logic [5:0] s1_src_reg;
  logic [3:0] s1_src_part;
  logic       dec_valid, dec_full_go, dec_lite_go, dec_single;
  logic [2:0] dec_why;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dual_issue_pair_chk u_dut (
    .clk(clk), .rst_n(rst_n),
    .s0_valid(s0_valid), .s0_cls(s0_cls), .s0_solo(s0_solo),
    .s0_dst_en(s0_dst_en), .s0_dst_reg(s0_dst_reg), .s0_dst_part(s0_dst_part),
    .s1_valid(s1_valid), .s1_cls(s1_cls), .s1_solo(s1_solo),
    .s1_dst_en(s1_dst_en), .s1_dst_reg(s1_dst_reg),
    .s1_src_en(s1_src_en), .s1_src_reg(s1_src_reg), .s1_src_part(s1_src_part),
    .dec_valid(dec_valid), .dec_full_go(dec_full_go), .dec_lite_go(dec_lite_go),
    .dec_single(dec_single), .dec_why(dec_why)
  );

  // Byte-lane masks: full=all four, half=lanes 0-1, low byte=lane 0, high byte=lane 1.
  function automatic logic [3:0] lane_mask(input logic [1:0] p);
    case (p)
      2'd0: return 4'b1111;
      2'd1: return 4'b0011;
      2'd2: return 4'b0001;
      default: return 4'b0010;
    endcase
  endfunction

  // Expected {valid, full, lite, single, why[2:0]}
  function automatic logic [6:0] model();
    logic [15:0] never_mask = 16'hFF00;
    logic [15:0] lite_mask  = 16'h003F;
    logic raw = 1'b0;
    logic waw;
    logic [2:0] w;
    if (!(s0_valid && s1_valid)) return 7'd0;
    for (int j = 0; j < 2; j++)
      if (s0_dst_en && s1_src_en[j] && s1_src_reg[3*j +: 3] == s0_dst_reg
          && (lane_mask(s0_dst_part) & lane_mask(s1_src_part[2*j +: 2])) != 4'd0)
        raw = 1'b1;
    waw = s0_dst_en && s1_dst_en && (s0_dst_reg == s1_dst_reg);
    if (never_mask[s0_cls] || never_mask[s1_cls] || s0_solo || s1_solo) w = 3'd3;
    else if (s0_cls == 4'd5)      w = 3'd5;
    else if (!lite_mask[s1_cls])  w = 3'd4;
    else if (raw)                 w = 3'd1;
    else if (waw)                 w = 3'd2;
    else                          w = 3'd0;
    return {1'b1, 1'b1, (w == 3'd0), (w != 3'd0), w};
  endfunction

  function automatic string tag_of(input logic [6:0] e);
    if (!e[6]) return "R1";
    case (e[2:0])
      3'd0: return "R10";
      3'd1: return "R5";
      3'd2: return "R7";
      3'd3: return "R2";
      3'd4: return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic compare(input string tag, input logic [6:0] got, input logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // Inputs already set at a negedge; outputs sampled 1 ns after the capturing edge.
  task automatic step(input string tag);
    logic [6:0] exp;
    logic [6:0] got;
    exp = model();
    @(posedge clk);
    #1;
    got = {dec_valid, dec_full_go, dec_lite_go, dec_single, dec_why};
    compare((tag == "") ? tag_of(exp) : tag, got, exp);
    if (dec_valid) compare("R9", {dec_full_go, dec_lite_go ^ dec_single}, 2'b11);
    @(negedge clk);
  endtask

  task automatic clear_slots();
    s0_valid = 1; s0_cls = 4'd2; s0_solo = 0; s0_dst_en = 1; s0_dst_reg = 3'd0; s0_dst_part = 2'd0;
    s1_valid = 1; s1_cls = 4'd2; s1_solo = 0; s1_dst_en = 1; s1_dst_reg = 3'd3;
    s1_src_en = 2'b11; s1_src_reg = {3'd2, 3'd1}; s1_src_part = 4'd0;
  endtask

  logic [31:0] rng = 32'h1234_5678;
  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    clear_slots();
    s0_valid = 0; s1_valid = 0;
    repeat (2) @(negedge clk);
    // R1: reset state, with valid slots presented during reset
    s0_valid = 1; s1_valid = 1;
    @(posedge clk); #1;
    compare("R1", {dec_valid, dec_full_go, dec_lite_go, dec_single, dec_why}, 7'd0);
    @(negedge clk);
    rst_n = 1;
    s0_valid = 0; s1_valid = 0;
    step("R1");
    s0_valid = 1; s1_valid = 0; step("R1");
    s0_valid = 0; s1_valid = 1; step("R1");
    clear_slots(); step("R10");

    // Class sweep: no register hazards, every class pairing (R2 R3 R4 R10)
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        clear_slots();
        s0_cls = 4'(a); s1_cls = 4'(b);
        step("");
      end

    // Solo attribute on either slot (R2)
    for (int k = 0; k < 4; k++) begin
      clear_slots();
      s0_solo = k[0]; s1_solo = k[1];
      step((k == 0) ? "R10" : "R2");
    end

    // Read-after-write over registers, parts and both source positions (R5 R6)
    for (int j = 0; j < 2; j++)
      for (int dr = 0; dr < 4; dr++)
        for (int dp = 0; dp < 4; dp++)
          for (int sr = 0; sr < 4; sr++)
            for (int sp = 0; sp < 4; sp++) begin
              clear_slots();
              s1_dst_en = 0;
              s0_dst_reg = 3'(dr); s0_dst_part = 2'(dp);
              s1_src_en = (j == 0) ? 2'b01 : 2'b10;
              s1_src_reg = {3'(sr), 3'(sr)}; s1_src_part = {2'(sp), 2'(sp)};
              step((dr == sr && ((dp == 2 && sp == 3) || (dp == 3 && sp == 2))) ? "R6" : "R5");
            end

    // Write-after-write including disjoint byte writes (R7)
    for (int en = 0; en < 4; en++)
      for (int ra = 0; ra < 4; ra++)
        for (int pa = 0; pa < 4; pa++)
          for (int rb = 0; rb < 4; rb++) begin
            clear_slots();
            s1_src_en = 2'b00;
            s0_dst_en = en[0]; s1_dst_en = en[1];
            s0_dst_reg = 3'(ra); s0_dst_part = 2'(pa); s1_dst_reg = 3'(rb);
            step("R7");
          end

    // Mixed pseudo-random traffic to exercise reason priority (R8)
    for (int n = 0; n < 3000; n++) begin
      rng = next_rng(rng);
      s0_valid = (rng[2:0] != 0); s1_valid = (rng[5:3] != 0);
      s0_cls = rng[9:6]; s1_cls = rng[13:10];
      s0_solo = (rng[16:14] == 0); s1_solo = (rng[19:17] == 0);
      s0_dst_en = rng[20]; s1_dst_en = rng[21];
      s0_dst_reg = {1'b0, rng[23:22]}; s1_dst_reg = {1'b0, rng[25:24]};
      s0_dst_part = rng[27:26];
      rng = next_rng(rng);
      s1_src_en = rng[1:0];
      s1_src_reg = {1'b0, rng[3:2], 1'b0, rng[5:4]};
      s1_src_part = rng[9:6];
      step("R8");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule